// File: doc/BRIEF.md
# Open-Drain Data Line Direction Arbiter

This block joins pairs of open-drain data lines, one on the host side and one on the card side, when no signal says which way the data flows. For each pair it samples both line levels and decides which side leads. The leading side's low level is then copied onto the other side through a pull-down enable. With no traffic, the pair rests in a neutral state in which neither pull-down is active.

The first side that pulls low while the other side is high becomes the master. The arbiter holds that direction until three things are true: the master line is high again, the copied low has drained out of the delay path, and the slave line has been seen high. The arbiter then returns to neutral. If both lines fall at once, the arbiter stays neutral. It never drives into a line that is already being pulled by the far side.

The main data pair and any auxiliary pairs use identical copies of the arbiter, one copy per lane. A session enable holds every lane in neutral with its pull-downs released. This covers the time before activation and the time during deactivation.

Top module: `line_dir_arbiter`

## Requirements
- R1: During reset, and in the first cycle after reset, both pull-down enables of every lane are 0, and each lane is in the neutral state.
- R2: Each line level passes through a SYNC_STAGES-flop synchroniser, followed by PROP_CYC cycles of propagation delay. A low on the master line therefore asserts the opposite pull-down exactly SYNC_STAGES+PROP_CYC rising clock edges after the raw line changes, and a return to high releases it after the same number of edges.
- R3: From neutral, with the session enabled, a low card line and a high host line make the card side master. The host pull-down then follows the card line level, inverted and delayed.
- R4: From neutral, with the session enabled, a low host line and a high card line make the host side master. The card pull-down then follows the host line level, inverted and delayed.
- R5: If both synchronised lines of a lane are low in the same cycle while the lane is neutral, the lane stays neutral and asserts no pull-down. The two pull-downs of a lane are never both asserted.
- R6: A master lane returns to neutral only once the master line is high, no low is pending in its delay path, and the slave line is seen high. After that, either side can become master.
- R7: While session_en is 0, both pull-downs of every lane are 0 in that same cycle, and every lane is forced to neutral. In the first cycle after session_en returns to 1, no pull-down is asserted.
- R8: Lanes are independent: activity on one lane never changes the pull-downs of another lane.
- R9: While a side is master, lows on the slave side are not copied back. The master side's pull-down stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| session_en | input | 1 | 1 while a card session is active; 0 holds all lanes neutral |
| host_in | input | LANES | Sensed host-side line levels, asynchronous |
| card_in | input | LANES | Sensed card-side line levels, asynchronous |
| host_pull | output | LANES | Pull-down enable for each host-side line |
| card_pull | output | LANES | Pull-down enable for each card-side line |

## Verification
The bench builds the arbiter with LANES=3 and PROP_CYC=3, and keeps the two-flop synchroniser. A delay longer than one cycle means each delay path can hold several pending lows at once. This exercises the rule that a master may not release until its delay path has emptied. Three lanes let the bench run simultaneous falls, direction changes and slave-side interference on one lane while checking that the other lanes stay quiet. Both the host and card line levels are built as wired-AND of the bench's own drive and the arbiter's pull-down. The arbiter's copied lows therefore feed back into its own inputs, as they do on a real bus.

// File: rtl/line_dir_arbiter.sv
module line_dir_arbiter #(
  parameter int LANES       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PROP_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             session_en,
  input  logic [LANES-1:0] host_in,
  input  logic [LANES-1:0] card_in,
  output logic [LANES-1:0] host_pull,
  output logic [LANES-1:0] card_pull
);

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_CARD = 2'd1;
  localparam logic [1:0] ST_HOST = 2'd2;
  localparam int         TAP     = PROP_CYC - 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SYNC_STAGES-1:0] h_sync, c_sync;
    logic [PROP_CYC-1:0]    h_low, c_low;
    logic [1:0]             st, st_nx;
    logic                   hs, cs;

    assign hs = h_sync[SYNC_STAGES-1];
    assign cs = c_sync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        h_sync <= '1;
        c_sync <= '1;
      end else begin
        h_sync <= {h_sync[SYNC_STAGES-2:0], host_in[g]};
        c_sync <= {c_sync[SYNC_STAGES-2:0], card_in[g]};
      end

    if (PROP_CYC == 1) begin : g_dly1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          h_low <= '0;
          c_low <= '0;
        end else begin
          h_low <= ~hs;
          c_low <= ~cs;
        end
    end else begin : g_dlyn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          h_low <= '0;
          c_low <= '0;
        end else begin
          h_low <= {h_low[PROP_CYC-2:0], ~hs};
          c_low <= {c_low[PROP_CYC-2:0], ~cs};
        end
    end

    always_comb begin
      st_nx = st;
      unique case (st)
        ST_CARD: if (cs && hs && c_low == '0) st_nx = ST_IDLE;
        ST_HOST: if (hs && cs && h_low == '0) st_nx = ST_IDLE;
        default: begin
          if (!cs && hs)      st_nx = ST_CARD;
          else if (!hs && cs) st_nx = ST_HOST;
          else                st_nx = ST_IDLE;
        end
      endcase
      if (!session_en) st_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;

    assign host_pull[g] = session_en && (st == ST_CARD) && c_low[TAP];
    assign card_pull[g] = session_en && (st == ST_HOST) && h_low[TAP];
  end

endmodule

// File: rtl/line_dir_arbiter_chk.sv
module line_dir_arbiter_chk #(
  parameter int LANES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             session_en,
  input logic [LANES-1:0] host_pull,
  input logic [LANES-1:0] card_pull
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (host_pull == '0 && card_pull == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_pull[g] && card_pull[g]));

    p_host_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_pull[g] |=> !card_pull[g]);

    p_card_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      card_pull[g] |=> !host_pull[g]);

    p_resume_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!session_en) && session_en) |-> (!host_pull[g] && !card_pull[g]));
  end

endmodule

bind line_dir_arbiter line_dir_arbiter_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .session_en(session_en),
  .host_pull(host_pull), .card_pull(card_pull)
);

// File: tb/line_dir_arbiter_tb.sv
module line_dir_arbiter_tb;
  localparam int L = 3;
  localparam int S = 2;
  localparam int D = 3;

  logic clk = 0, rst_n = 0, session_en = 0;
  logic [L-1:0] host_ext = '1, card_ext = '1;
  logic [L-1:0] host_pull, card_pull;
  wire  [L-1:0] host_line = host_ext & ~host_pull;
  wire  [L-1:0] card_line = card_ext & ~card_pull;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  line_dir_arbiter #(.LANES(L), .SYNC_STAGES(S), .PROP_CYC(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .session_en(session_en),
    .host_in(host_line), .card_in(card_line),
    .host_pull(host_pull), .card_pull(card_pull));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 neutral, 1 card leads, 2 host leads
  int mst[L];
  bit hq[L][$], cq[L][$], hdq[L][$], cdq[L][$];

  task automatic model_reset();
    for (int i = 0; i < L; i++) begin
      mst[i] = 0;
      hq[i] = {}; cq[i] = {}; hdq[i] = {}; cdq[i] = {};
      for (int k = 0; k < S; k++) begin hq[i].push_back(1); cq[i].push_back(1); end
      for (int k = 0; k < D; k++) begin hdq[i].push_back(1); cdq[i].push_back(1); end
    end
  endtask

  initial model_reset();

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int i = 0; i < L; i++) begin
        bit hs, cs, hpend, cpend;
        chk("R3 host pull vs model", host_pull[i], session_en && mst[i] == 1 && cdq[i][D-1] == 0);
        chk("R4 card pull vs model", card_pull[i], session_en && mst[i] == 2 && hdq[i][D-1] == 0);
        hs = hq[i][S-1]; cs = cq[i][S-1];
        hpend = 0; cpend = 0;
        foreach (hdq[i][k]) if (!hdq[i][k]) hpend = 1;
        foreach (cdq[i][k]) if (!cdq[i][k]) cpend = 1;
        if (!session_en) mst[i] = 0;
        else if (mst[i] == 0) begin
          if (!cs && hs) mst[i] = 1;
          else if (!hs && cs) mst[i] = 2;
        end else if (mst[i] == 1) begin
          if (cs && hs && !cpend) mst[i] = 0;
        end else if (hs && cs && !hpend) mst[i] = 0;
        cdq[i].push_front(cs); void'(cdq[i].pop_back());
        hdq[i].push_front(hs); void'(hdq[i].pop_back());
        cq[i].push_front(card_line[i]); void'(cq[i].pop_back());
        hq[i].push_front(host_line[i]); void'(hq[i].pop_back());
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic quiet(input string req, input int lane);
    chk(req, host_pull[lane], 1'b0);
    chk(req, card_pull[lane], 1'b0);
  endtask

  initial begin
    #200_000_0;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    for (int i = 0; i < L; i++) quiet("R1 reset", i);
    rst_n = 1;
    #5 for (int i = 0; i < L; i++) quiet("R1 after reset", i);

    // R7: session off, card lows are not copied
    step(1); card_ext[0] = 0; host_ext[1] = 0;
    step(10); quiet("R7 idle session", 0); quiet("R7 idle session", 1);
    card_ext[0] = 1; host_ext[1] = 1;
    step(6); session_en = 1;
    #5 quiet("R7 resume", 0);

    // R2, R3: card leads, exact latency
    step(2); card_ext[0] = 0;
    step(S + D - 1); #5 chk("R2 before latency", host_pull[0], 1'b0);
    step(1); #5 chk("R3 host copies card", host_pull[0], 1'b1);
    quiet("R8 other lane", 1); quiet("R8 other lane", 2);
    // R9: host tries to pull while slave
    step(1); host_ext[0] = 0;
    step(6); #5 chk("R9 no copy back", card_pull[0], 1'b0);
    host_ext[0] = 1;
    step(2); card_ext[0] = 1;
    step(S + D - 1); #5 chk("R2 release latency", host_pull[0], 1'b1);
    step(1); #5 chk("R2 released", host_pull[0], 1'b0);

    // R6, R4: return to neutral, then host leads
    step(6); host_ext[0] = 0;
    step(S + D); #5 chk("R4 card copies host", card_pull[0], 1'b1);
    chk("R4 host side quiet", host_pull[0], 1'b0);
    step(1); host_ext[0] = 1;
    step(S + D); #5 chk("R6 card released", card_pull[0], 1'b0);

    // R5: simultaneous fall on lane 1
    step(4); host_ext[1] = 0; card_ext[1] = 0;
    step(12); quiet("R5 both low stays neutral", 1);
    card_ext[1] = 1;
    step(S + D + 1); #5 chk("R5 then host leads", card_pull[1], 1'b1);
    host_ext[1] = 1;
    step(12); quiet("R6 lane1 back to neutral", 1);

    // R7: session drop in mid transfer on lane 2
    card_ext[2] = 0;
    step(S + D + 2); #5 chk("R3 lane2 card leads", host_pull[2], 1'b1);
    quiet("R8 lane0 untouched", 0);
    step(1); session_en = 0;
    #1 chk("R7 same cycle release", host_pull[2], 1'b0);
    step(4); card_ext[2] = 1;
    step(10); session_en = 1;
    #5 quiet("R7 resume idle", 2);
    step(10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule